// File: doc/BRIEF.md
# Dual-Style Three-Character Sequence Detector

This block watches a stream of 8-bit character codes, each presented together with a one-cycle valid strobe. It looks for the ordered pattern `H`, `i`, `!` and reports each match on two outputs that are built in different styles.

The first output comes from an input-dependent (Mealy) machine. It rises within the same cycle in which the closing `!` is presented with its strobe. The second output comes from a state-only (Moore) machine. It rises one clock later, from a dedicated "found" state, and holds steady until the next strobed character, whatever the character input does in between.

A character that does not continue the pattern abandons the attempt. If that character is itself an `H`, a new attempt begins at once, so overlapping tries are not lost.

Both machines share a single comparison stage. That stage turns the incoming character into a small bundle of match strobes, which both control machines consume.

Top module: `seq_detect_dual`

## Requirements
- R1: A synchronous active-high `rst` returns both machines to idle. While in reset and just after it, `mooreDetect` is 0 and `mealyDetect` is 0 when no strobe is present. A partial pattern entered before reset does not complete after it.
- R2: When `charValid` is 1, the prior accepted characters were `H` (0x48) then `i` (0x69), and `charCode` is `!` (0x21), `mealyDetect` is 1 in that same cycle, before the clock edge.
- R3: `mealyDetect` is 0 whenever `charValid` is 0, or `charCode` is not `!`, or the pattern prefix has not been seen. Within one cycle it follows changes of `charCode`.
- R4: `mooreDetect` becomes 1 at the clock edge that accepts the closing `!`. It stays 1 through cycles without a strobe and drops at the next edge that accepts any strobed character.
- R5: `mooreDetect` depends only on the stored state: it does not change between clock edges while `charCode` or `charValid` change.
- R6: Cycles with `charValid` at 0 leave both machines unchanged, whatever `charCode` carries.
- R7: A strobed character other than the expected next one (and other than `H`) returns both machines to idle, so a later `!` does not produce a detect.
- R8: A strobed `H` that breaks the pattern moves both machines to the "seen H" state. So `H H i !` and `H i H i !` each produce a detect.
- R9: After a detect both machines restart. Back-to-back patterns `H i ! H i !` detect twice, and `H i ! !` detects once.
- R10: Codes are compared exactly on all 8 bits. Lower-case `h` (0x68) does not start a pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| charValid | input | 1 | Strobe marking a new character this cycle |
| charCode | input | 8 | Character code |
| mealyDetect | output | 1 | Same-cycle detect, from state and input |
| mooreDetect | output | 1 | Registered detect, from state only |

## Verification
The bench builds the block with its default parameters: 8-bit characters and the three codes 0x48, 0x69 and 0x21. All three codes differ from one another, so the restart-on-`H` priority is reached without any ambiguity between pattern positions. The lower-case `h` case probes a single-bit difference against the first code. The bench changes the character code inside a single clock period, both with and without a strobe. This makes the combinational response of one output and the held value of the other visible in the same run.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // Match strobes handed from the compare datapath to both controllers.
  typedef struct packed {
    logic advance;    // a character is being accepted this cycle
    logic hitFirst;   // accepted character equals pattern position 0
    logic hitSecond;  // accepted character equals pattern position 1
    logic hitThird;   // accepted character equals pattern position 2
  } matchStrobes_t;

  typedef enum logic [1:0] {
    MEALY_IDLE = 2'd0,
    MEALY_GOT1 = 2'd1,
    MEALY_GOT2 = 2'd2
  } mealyState_t;

  typedef enum logic [1:0] {
    MOORE_IDLE  = 2'd0,
    MOORE_GOT1  = 2'd1,
    MOORE_GOT2  = 2'd2,
    MOORE_FOUND = 2'd3
  } mooreState_t;

endpackage

// File: rtl/seqdet_match.sv
module seqdet_match
  import seqdet_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] FIRST_CODE  = 8'h48,
  parameter logic [CHAR_W-1:0] SECOND_CODE = 8'h69,
  parameter logic [CHAR_W-1:0] THIRD_CODE  = 8'h21
) (
  input  logic              charValid,
  input  logic [CHAR_W-1:0] charCode,
  output matchStrobes_t     strobes
);

  localparam int SEQ_LEN = 3;

  logic [CHAR_W-1:0] patternCodes [SEQ_LEN];
  logic [SEQ_LEN-1:0] posHit;

  assign patternCodes[0] = FIRST_CODE;
  assign patternCodes[1] = SECOND_CODE;
  assign patternCodes[2] = THIRD_CODE;

  for (genvar p = 0; p < SEQ_LEN; p++) begin : g_cmp
    assign posHit[p] = charValid && (charCode == patternCodes[p]);
  end

  always_comb begin
    strobes.advance   = charValid;
    strobes.hitFirst  = posHit[0];
    strobes.hitSecond = posHit[1];
    strobes.hitThird  = posHit[2];
  end

endmodule

// File: rtl/seqdet_mealy.sv
module seqdet_mealy
  import seqdet_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  matchStrobes_t strobes,
  output logic          detect
);

  mealyState_t curState, nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      MEALY_IDLE: begin
        if (strobes.hitFirst) nextState = MEALY_GOT1;
      end
      MEALY_GOT1: begin
        if (strobes.hitSecond)     nextState = MEALY_GOT2;
        else if (strobes.hitFirst) nextState = MEALY_GOT1;
        else if (strobes.advance)  nextState = MEALY_IDLE;
      end
      MEALY_GOT2: begin
        if (strobes.hitThird)      nextState = MEALY_IDLE;
        else if (strobes.hitFirst) nextState = MEALY_GOT1;
        else if (strobes.advance)  nextState = MEALY_IDLE;
      end
      default: nextState = MEALY_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= MEALY_IDLE;
    else     curState <= nextState;
  end

  // Output formed from state and the live input strobes.
  assign detect = (curState == MEALY_GOT2) && strobes.hitThird;

endmodule

// File: rtl/seqdet_moore.sv
module seqdet_moore
  import seqdet_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  matchStrobes_t strobes,
  output logic          detect
);

  mooreState_t curState, nextState;

  always_comb begin
    nextState = curState;
    unique case (curState)
      MOORE_IDLE, MOORE_FOUND: begin
        if (strobes.hitFirst)     nextState = MOORE_GOT1;
        else if (strobes.advance) nextState = MOORE_IDLE;
      end
      MOORE_GOT1: begin
        if (strobes.hitSecond)     nextState = MOORE_GOT2;
        else if (strobes.hitFirst) nextState = MOORE_GOT1;
        else if (strobes.advance)  nextState = MOORE_IDLE;
      end
      MOORE_GOT2: begin
        if (strobes.hitThird)      nextState = MOORE_FOUND;
        else if (strobes.hitFirst) nextState = MOORE_GOT1;
        else if (strobes.advance)  nextState = MOORE_IDLE;
      end
      default: nextState = MOORE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) curState <= MOORE_IDLE;
    else     curState <= nextState;
  end

  // Output decoded from stored state only.
  assign detect = (curState == MOORE_FOUND);

endmodule

// File: rtl/seq_detect_dual.sv
module seq_detect_dual
  import seqdet_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] FIRST_CODE  = 8'h48,
  parameter logic [CHAR_W-1:0] SECOND_CODE = 8'h69,
  parameter logic [CHAR_W-1:0] THIRD_CODE  = 8'h21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              charValid,
  input  logic [CHAR_W-1:0] charCode,
  output logic              mealyDetect,
  output logic              mooreDetect
);

  matchStrobes_t matchBus;

  seqdet_match #(
    .CHAR_W     (CHAR_W),
    .FIRST_CODE (FIRST_CODE),
    .SECOND_CODE(SECOND_CODE),
    .THIRD_CODE (THIRD_CODE)
  ) u_match (
    .charValid(charValid),
    .charCode (charCode),
    .strobes  (matchBus)
  );

  seqdet_mealy u_mealy (
    .clk    (clk),
    .rst    (rst),
    .strobes(matchBus),
    .detect (mealyDetect)
  );

  seqdet_moore u_moore (
    .clk    (clk),
    .rst    (rst),
    .strobes(matchBus),
    .detect (mooreDetect)
  );

endmodule

// File: rtl/seqdet_checker.sv
module seqdet_checker #(
  parameter int CHAR_W = 8,
  parameter logic [CHAR_W-1:0] THIRD_CODE = 8'h21
) (
  input logic              clk,
  input logic              rst,
  input logic              charValid,
  input logic [CHAR_W-1:0] charCode,
  input logic              mealyDetect,
  input logic              mooreDetect
);

  AST_MEALY_NEEDS_CLOSER: assert property (@(posedge clk) disable iff (rst)
    mealyDetect |-> (charValid && charCode == THIRD_CODE)); // R3

  AST_MOORE_FOLLOWS_MEALY: assert property (@(posedge clk) disable iff (rst)
    mealyDetect |=> mooreDetect); // R4

  AST_MOORE_RISE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    $rose(mooreDetect) |-> $past(mealyDetect)); // R4

  AST_MOORE_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (mooreDetect && charValid) |=> !mooreDetect); // R4

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !charValid |=> $stable(mooreDetect)); // R6

endmodule

bind seq_detect_dual seqdet_checker #(
  .CHAR_W    (CHAR_W),
  .THIRD_CODE(THIRD_CODE)
) u_checker (
  .clk        (clk),
  .rst        (rst),
  .charValid  (charValid),
  .charCode   (charCode),
  .mealyDetect(mealyDetect),
  .mooreDetect(mooreDetect)
);

// File: tb/seq_detect_dual_test.sv
module seq_detect_dual_test;

  localparam logic [7:0] CH_H   = 8'h48;
  localparam logic [7:0] CH_I   = 8'h69;
  localparam logic [7:0] CH_EX  = 8'h21;
  localparam logic [7:0] CH_X   = 8'h78;
  localparam logic [7:0] CH_LOW = 8'h68;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       charValid = 1'b0;
  logic [7:0] charCode = 8'h00;
  logic       mealyDetect, mooreDetect;

  int compared = 0;
  int mismatched = 0;

  always #10 clk = ~clk;

  seq_detect_dual uut (
    .clk        (clk),
    .rst        (rst),
    .charValid  (charValid),
    .charCode   (charCode),
    .mealyDetect(mealyDetect),
    .mooreDetect(mooreDetect)
  );

  task automatic check(input string tag, input logic actual, input logic expected);
    compared++;
    if (actual !== expected) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, actual, expected, $time);
    end
  endtask

  // Drive at the falling edge, check Mealy before the rising edge, Moore after it.
  task automatic step(input logic v, input logic [7:0] c,
                      input logic eMealy, input logic eMoore, input string tag);
    @(negedge clk);
    charValid = v;
    charCode  = c;
    #5;
    check({tag, " mealy"}, mealyDetect, eMealy);
    @(posedge clk);
    #2;
    check({tag, " moore"}, mooreDetect, eMoore);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rst = 1'b1;
    charValid = 1'b0;
    @(posedge clk);
    #2;
    check("R1 reset moore", mooreDetect, 1'b0);
    check("R1 reset mealy", mealyDetect, 1'b0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic testBasic();
    resetDut();
    step(1, CH_H, 0, 0, "R2 basic H");
    step(1, CH_I, 0, 0, "R2 basic i");
    step(1, CH_EX, 1, 1, "R2 basic !");
    step(0, CH_EX, 0, 1, "R4 hold idle");
    step(1, CH_X, 0, 0, "R4 drop on strobe");
  endtask

  task automatic testGaps();
    resetDut();
    step(1, CH_H, 0, 0, "R6 gap H");
    step(0, CH_X, 0, 0, "R6 gap idle x");
    step(1, CH_I, 0, 0, "R6 gap i");
    step(0, CH_H, 0, 0, "R6 gap idle H");
    step(0, CH_EX, 0, 0, "R3 unstrobed closer");
    step(1, CH_EX, 1, 1, "R6 gap !");
  endtask

  task automatic testBreak();
    resetDut();
    step(1, CH_H, 0, 0, "R7 brk H");
    step(1, CH_I, 0, 0, "R7 brk i");
    step(1, CH_X, 0, 0, "R7 brk x");
    step(1, CH_EX, 0, 0, "R7 brk ! after x");
    step(1, CH_H, 0, 0, "R7 brk2 H");
    step(1, CH_X, 0, 0, "R7 brk2 x");
    step(1, CH_I, 0, 0, "R7 brk2 i");
    step(1, CH_EX, 0, 0, "R7 brk2 !");
  endtask

  task automatic testRestart();
    resetDut();
    step(1, CH_H, 0, 0, "R8 HH first");
    step(1, CH_H, 0, 0, "R8 HH second");
    step(1, CH_I, 0, 0, "R8 HH i");
    step(1, CH_EX, 1, 1, "R8 HH !");
    step(1, CH_H, 0, 0, "R8 HiH H");
    step(1, CH_I, 0, 0, "R8 HiH i");
    step(1, CH_H, 0, 0, "R8 HiH H2");
    step(1, CH_I, 0, 0, "R8 HiH i2");
    step(1, CH_EX, 1, 1, "R8 HiH !");
  endtask

  task automatic testBackToBack();
    resetDut();
    step(1, CH_H, 0, 0, "R9 b2b H");
    step(1, CH_I, 0, 0, "R9 b2b i");
    step(1, CH_EX, 1, 1, "R9 b2b !");
    step(1, CH_H, 0, 0, "R9 b2b H2");
    step(1, CH_I, 0, 0, "R9 b2b i2");
    step(1, CH_EX, 1, 1, "R9 b2b !2");
    step(1, CH_EX, 0, 0, "R9 repeated !");
  endtask

  task automatic testStability();
    resetDut();
    step(1, CH_H, 0, 0, "R5 H");
    step(1, CH_I, 0, 0, "R5 i");
    // Strobed but the code wobbles within the cycle: Mealy follows it.
    @(negedge clk);
    charValid = 1'b1;
    charCode  = CH_X;
    #2 check("R3 wobble x", mealyDetect, 1'b0);
    charCode = CH_EX;
    #2 check("R2 wobble !", mealyDetect, 1'b1);
    charValid = 1'b0;
    #2 check("R3 wobble strobe low", mealyDetect, 1'b0);
    charValid = 1'b1;
    #2;
    @(posedge clk);
    #2 check("R4 wobble moore", mooreDetect, 1'b1);
    // Unstrobed: inputs change, Moore output must not move.
    @(negedge clk);
    charValid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      charCode = CH_H + 8'(k);
      #2 check("R5 stable moore", mooreDetect, 1'b1);
    end
    charValid = 1'b1;
    charCode  = CH_X;
    #1 check("R5 stable with strobe", mooreDetect, 1'b1);
    @(posedge clk);
    #2 check("R4 moore cleared", mooreDetect, 1'b0);
  endtask

  task automatic testResetMid();
    resetDut();
    step(1, CH_H, 0, 0, "R1 mid H");
    step(1, CH_I, 0, 0, "R1 mid i");
    resetDut();
    step(1, CH_EX, 0, 0, "R1 ! after reset");
  endtask

  task automatic testCase();
    resetDut();
    step(1, CH_LOW, 0, 0, "R10 lower h");
    step(1, CH_I, 0, 0, "R10 i");
    step(1, CH_EX, 0, 0, "R10 !");
  endtask

  initial begin
    #(20 * 100000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    testBasic();
    testGaps();
    testBreak();
    testRestart();
    testBackToBack();
    testStability();
    testResetMid();
    testCase();
    @(negedge clk);
    charValid = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule